// File: doc/BRIEF.md
# Sub-cycle dithered PWM generator

This block drives one PWM output from an 8-bit duty word. It does not produce a single pulse per 256-tick frame. It splits the frame into four sub-cycles of 64 ticks each, so the output repeats four times as fast as a plain 8-bit PWM. The six upper duty bits set a base high time that every sub-cycle receives. The two lower bits set how many sub-cycles, starting from the first, get one extra high tick. The average duty over a frame is therefore still duty/256, but the ripple frequency is four times higher.

The tick counter advances once every `TICK_DIV` clocks, which defaults to two. Within each sub-cycle the pulse starts at the sub-cycle boundary. The duty word is sampled only when a frame begins, so a write never tears a running frame. A one-clock strobe marks every frame start. While the enable input is low, the output is low and the counters stay at zero.

Top module: `dpwm_top`

## Requirements
- R1: The tick counter advances by one every `TICK_DIV` (2) clocks. A frame is 256 ticks (512 clocks), made of four sub-cycles of 64 ticks (128 clocks). The counter's two upper bits select the sub-cycle and its six lower bits give the position inside it.
- R2: With base B = duty[7:2] and extra count X = duty[1:0], sub-cycle i (0..3) is high for B+1 ticks when i < X and for B ticks otherwise. Examples: 100 gives 25,25,25,25; 101 gives 26,25,25,25; 102 gives 26,26,25,25; 103 gives 26,26,26,25.
- R3: Within a sub-cycle the output is high from position 0 until the high time is used up, then low until the sub-cycle ends. There is at most one contiguous pulse per sub-cycle.
- R4: A new duty word takes effect only at the next frame start. A change in the middle of a frame leaves the rest of that frame unchanged.
- R5: Duty 0 keeps the output low for the whole frame. Duty 255 gives high times of 64,64,64,63 ticks.
- R6: While enable is low, the output and the strobe are low and the counter is held at zero. This takes effect from the clock after enable is sampled low.
- R7: On the first clock edge that samples enable high after it was low, a new frame starts. The strobe goes high, the counter is at 0 and the current duty word is captured.
- R8: The strobe is high for exactly one clock per frame. It is high only while the counter is 0, and its rising edges are 512 clocks apart.
- R9: During reset the output and the strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds the block idle |
| duty_i | input | 8 | Duty word, sampled at each frame start |
| pwm_o | output | 1 | Registered PWM output |
| period_start_o | output | 1 | One-clock strobe at each frame start |

## Verification
Two events can fall on the same clock edge: the wrap of the tick counter at the end of a frame and the capture of a duty word that changed during that frame. Enable rising likewise coincides with a frame start and a duty capture. The bench changes the duty word partway through each frame so that a new value is always waiting at the wrap. It also rewrites the duty word while the block is disabled, just before enabling it again. A scoreboard measures the high time of each sub-cycle and compares it with the value expected from the word that was current at the frame start. A value taken early or late shows up as a wrong count in a sub-cycle of the affected frame.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int unsigned DEF_CNT_W    = 8;
    localparam int unsigned DEF_SUB_W    = 2;
    localparam int unsigned DEF_TICK_DIV = 2;

endpackage

// File: rtl/dpwm_ticker.sv
module dpwm_ticker #(
    parameter int unsigned TICK_DIV = dpwm_pkg::DEF_TICK_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!en_i || !run_i) begin
            div_d = '0;
        end else if (div_q == LAST) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = run_i && (div_q == LAST);

endmodule

// File: rtl/dpwm_sequencer.sv
module dpwm_sequencer
    import dpwm_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] duty_d_o,
    output logic [CNT_W-1:0] duty_q_o,
    output logic             strobe_q_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] duty;
        logic             strobe;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (!en_i) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_IDLE) begin
            st_d.phase  = PH_RUN;
            st_d.cnt    = '0;
            st_d.duty   = duty_i;
            st_d.strobe = 1'b1;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_LAST) begin
                st_d.duty   = duty_i;
                st_d.strobe = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, duty: '0, strobe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = (st_q.phase == PH_RUN);
    assign cnt_d_o    = st_d.cnt;
    assign cnt_q_o    = st_q.cnt;
    assign duty_d_o   = st_d.duty;
    assign duty_q_o   = st_q.duty;
    assign strobe_q_o = st_q.strobe;

endmodule

// File: rtl/dpwm_shaper.sv
module dpwm_shaper #(
    parameter int unsigned CNT_W = dpwm_pkg::DEF_CNT_W,
    parameter int unsigned SUB_W = dpwm_pkg::DEF_SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);
    localparam int unsigned POS_W = CNT_W - SUB_W;

    logic [SUB_W-1:0] sub_idx, extra_cnt;
    logic [POS_W-1:0] pos, base;
    logic [POS_W:0]   high_len;
    logic             pwm_d, pwm_q;

    always_comb begin
        sub_idx   = cnt_i[CNT_W-1:POS_W];
        pos       = cnt_i[POS_W-1:0];
        base      = duty_i[CNT_W-1:SUB_W];
        extra_cnt = duty_i[SUB_W-1:0];
        high_len  = {1'b0, base} + {{POS_W{1'b0}}, (sub_idx < extra_cnt)};
        pwm_d     = en_i && ({1'b0, pos} < high_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= pwm_d;
        end
    end

    assign pwm_o = pwm_q;

endmodule

// File: rtl/dpwm_top.sv
module dpwm_top #(
    parameter int unsigned CNT_W    = dpwm_pkg::DEF_CNT_W,
    parameter int unsigned SUB_W    = dpwm_pkg::DEF_SUB_W,
    parameter int unsigned TICK_DIV = dpwm_pkg::DEF_TICK_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o,
    output logic             period_start_o
);
    logic             run_q;
    logic             tick;
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] duty_d, duty_q;
    logic             strobe_q;

    dpwm_ticker #(
        .TICK_DIV (TICK_DIV)
    ) ticker_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .run_i  (run_q),
        .tick_o (tick)
    );

    dpwm_sequencer #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .tick_i     (tick),
        .duty_i     (duty_i),
        .run_o      (run_q),
        .cnt_d_o    (cnt_d),
        .cnt_q_o    (cnt_q),
        .duty_d_o   (duty_d),
        .duty_q_o   (duty_q),
        .strobe_q_o (strobe_q)
    );

    dpwm_shaper #(
        .CNT_W (CNT_W),
        .SUB_W (SUB_W)
    ) shaper_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .cnt_i  (cnt_d),
        .duty_i (duty_d),
        .pwm_o  (pwm_o)
    );

    assign period_start_o = strobe_q;

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker #(
    parameter int unsigned CNT_W = dpwm_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic             pwm_o,
    input logic             period_start_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] duty_q
);

    // R1: the counter moves only in unit steps while running
    p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && (cnt_q != $past(cnt_q))) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R8: strobe only at counter zero
    p_strobe_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> (cnt_q == '0));

    // R6: idle behaviour after enable sampled low
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!pwm_o && !period_start_o && (cnt_q == '0)));

    // R7: enable rising starts a frame on the next clock
    p_first_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |=> period_start_o);

    // R4: the held duty word changes only with a frame start
    p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start_o |-> $stable(duty_q));

    // R5: zero duty never drives the output high
    p_zero_duty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |-> !pwm_o);

endmodule

bind dpwm_top dpwm_checker #(
    .CNT_W (CNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_i           (en_i),
    .pwm_o          (pwm_o),
    .period_start_o (period_start_o),
    .cnt_q          (cnt_q),
    .duty_q         (duty_q)
);

// File: tb/dpwm_top_tb_top.sv
module dpwm_top_tb_top;

    typedef struct {
        int    ticks;
        string tag;
    } exp_t;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       en    = 1'b0;
    logic [7:0] duty  = 8'd0;
    logic       pwm;
    logic       strobe;

    int   checks = 0;
    int   fails  = 0;
    exp_t expq[$];

    // monitor state
    bit   prev_en  = 1'b0;
    bit   prev2_en = 1'b0;
    bit   started  = 1'b0;
    bit   seen_low = 1'b0;
    int   clk_cnt  = 0;
    int   hi_cnt   = 0;
    exp_t cur;

    always #4 clk = ~clk;

    dpwm_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_i           (en),
        .duty_i         (duty),
        .pwm_o          (pwm),
        .period_start_o (strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver side: expected high ticks per sub-cycle from the requirements
    task automatic push_duty(input int v, input string tag);
        for (int i = 0; i < 4; i++) begin
            exp_t e;
            e.ticks = (v >> 2) + ((i < (v & 3)) ? 1 : 0);
            e.tag   = tag;
            expq.push_back(e);
        end
    endtask

    task automatic drive_wait(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_strobe();
        do @(negedge clk); while (strobe !== 1'b1);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!prev_en) begin
                check(!pwm && !strobe, "R6", "idle output/strobe", {pwm, strobe}, 0);
                started  = 1'b0;
            end else begin
                if (!prev2_en) begin
                    check(strobe, "R7", "strobe on first enabled clock", strobe, 1);
                end
                if (strobe) begin
                    if (started) begin
                        check(clk_cnt == 512, "R8", "clocks between strobes", clk_cnt, 512);
                    end
                    started  = 1'b1;
                    clk_cnt  = 0;
                    hi_cnt   = 0;
                    seen_low = 1'b0;
                end
                if (started) begin
                    if (pwm) begin
                        if (seen_low) begin
                            check(1'b0, "R3", "second pulse in sub-cycle", clk_cnt, -1);
                        end
                        hi_cnt++;
                    end else begin
                        seen_low = 1'b1;
                    end
                    if ((clk_cnt % 128) == 127) begin
                        if (expq.size() == 0) begin
                            check(1'b0, "R1", "sub-cycle with no expectation", hi_cnt, -1);
                        end else begin
                            cur = expq.pop_front();
                            check(hi_cnt == 2 * cur.ticks, cur.tag, "sub-cycle high clocks",
                                  hi_cnt, 2 * cur.ticks);
                        end
                        hi_cnt   = 0;
                        seen_low = 1'b0;
                    end
                    clk_cnt++;
                end
            end
            prev2_en = prev_en;
            prev_en  = en;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int    vals[7] = '{101, 102, 103, 0, 255, 128, 77};
        string tags[7] = '{"R2", "R2", "R2/R4", "R5", "R5", "R4", "R2"};

        repeat (3) @(negedge clk);
        check(!pwm && !strobe, "R9", "outputs in reset", {pwm, strobe}, 0);
        drive_wait(1);
        rst_n = 1'b1;
        drive_wait(3);

        // first frame: 25 ticks in each sub-cycle
        duty = 8'd100;
        push_duty(100, "R2");
        en = 1'b1;

        // change the word mid-frame; it must land on the next frame only
        for (int k = 0; k < 7; k++) begin
            wait_strobe();
            drive_wait(250);
            duty = vals[k][7:0];
            push_duty(vals[k], tags[k]);
        end

        // word left unchanged: next frame repeats it
        wait_strobe();
        push_duty(77, "R4");
        wait_strobe();
        drive_wait(200);

        // disable mid-frame; remaining expectations are void
        en = 1'b0;
        expq.delete();
        drive_wait(10);
        duty = 8'd7;
        drive_wait(30);

        // re-enable: new word captured at once, 2,2,2,1 ticks
        push_duty(7, "R7");
        en = 1'b1;
        wait_strobe();
        drive_wait(530);
        en = 1'b0;
        drive_wait(1);
        check(expq.size() == 0, "R1", "expectations left over", expq.size(), 0);
        drive_wait(10);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule